// File: doc/BRIEF.md
# Width-selectable shift, rotate and step unit

This unit carries out the modify step of a read-modify-write instruction. On a start strobe it takes an operation code, a width mode, a target select, the accumulator value, a memory operand value and the current carry flag. It shifts, rotates through carry, increments or decrements the operand that the target select picks. One clock edge later it presents the result for one cycle, together with new negative, zero and carry flags.

A result aimed at the accumulator comes back on the accumulator port with an accumulator write enable. A result aimed at memory comes back on a write-data port with a memory write enable, and the accumulator is left alone. In 8-bit mode the unit works on the low byte only. For the accumulator, the high byte of the value returned is the high byte that came in. Memory bus timing and address generation are handled outside the unit.

Top module: `bitstep_unit`

## Requirements
- R1: While rst_ni is low, valid_o, acc_we_o and mem_we_o are 0, and acc_o, mem_wdata_o, neg_o, zero_o and carry_o are 0.
- R2: Code 0 (shift left) moves the top bit of the selected width (bit 7 when wide_i is 0, bit 15 when it is 1) into carry and puts 0 into bit 0.
- R3: Code 1 (shift right) moves bit 0 into carry and puts 0 into the top bit of the selected width.
- R4: Code 2 (rotate left) puts carry_i into bit 0 and moves the old top bit of the selected width into carry.
- R5: Code 3 (rotate right) puts carry_i into the top bit of the selected width and moves the old bit 0 into carry.
- R6: Code 4 (increment) and code 5 (decrement) wrap modulo 2^width, and carry_o takes the value of carry_i.
- R7: For every valid code, neg_o is the top bit of the result at the selected width and zero_o is 1 exactly when all bits of that width are 0.
- R8: When to_mem_i is 0 and wide_i is 0, acc_o[15:8] equals acc_i[15:8] and only the low byte holds the result.
- R9: When to_mem_i is 1, the operand is mem_i. The result appears on mem_wdata_o, with bits 15:8 at 0 in 8-bit mode, and mem_we_o pulses. acc_we_o stays 0 and acc_o keeps its previous value. When to_mem_i is 0, the operand is acc_i, acc_we_o pulses and mem_wdata_o keeps its previous value.
- R10: Codes 6 and 7 give no valid_o and no write enable, and leave every output value unchanged.
- R11: valid_o is 1 exactly in the cycle after a start_i with a valid code, and the outputs sampled in that cycle belong to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, one cycle |
| op_i | input | 3 | Operation code 0..5; 6 and 7 are invalid |
| wide_i | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| to_mem_i | input | 1 | 1 selects the memory operand as target, 0 the accumulator |
| acc_i | input | 16 | Current accumulator value |
| mem_i | input | 16 | Memory operand value |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Result strobe |
| acc_we_o | output | 1 | Accumulator write enable |
| acc_o | output | 16 | New accumulator value |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 16 | Memory write data |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |

## Verification
The assertions assume that the request inputs (start_i, op_i, wide_i, to_mem_i, acc_i, mem_i, carry_i) are steady around each rising edge, and that start_i is low while reset is asserted. The bench drives every input on the falling edge and holds it through the next rising edge. It returns start_i to 0 before any check, so each request is a single clean pulse. Random requests draw codes from the whole 3-bit range, so the invalid codes 6 and 7 land between valid requests. Their effect on the held outputs is then checked against the previous values.

// File: rtl/bitstep_pkg.sv
package bitstep_pkg;
  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_ROL = 3'd2,
    OP_ROR = 3'd3,
    OP_INC = 3'd4,
    OP_DEC = 3'd5
  } op_e;

  function automatic logic op_known(logic [2:0] op);
    return op <= 3'd5;
  endfunction
endpackage

// File: rtl/bitstep_alu.sv
module bitstep_alu
  import bitstep_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic [2:0]    op_i,
  input  logic          wide_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          carry_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o
);
  localparam logic [DW-1:0] NMASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  logic [DW-1:0] opn, raw;
  logic          top;

  assign opn = wide_i ? opnd_i : (opnd_i & NMASK);
  assign top = wide_i ? opn[DW-1] : opn[NW-1];

  always_comb begin
    raw     = opn;
    carry_o = carry_i;
    unique case (op_e'(op_i))
      OP_SHL: begin raw = opn << 1; carry_o = top; end
      OP_SHR: begin raw = opn >> 1; carry_o = opn[0]; end
      OP_ROL: begin raw = (opn << 1) | {{(DW-1){1'b0}}, carry_i}; carry_o = top; end
      OP_ROR: begin
        raw = opn >> 1;
        if (wide_i) raw[DW-1] = carry_i;
        else        raw[NW-1] = carry_i;
        carry_o = opn[0];
      end
      OP_INC: raw = opn + 1'b1;
      OP_DEC: raw = opn - 1'b1;
      default: begin raw = opn; carry_o = carry_i; end
    endcase
  end

  // narrow results are cleared above the selected width
  assign res_o = wide_i ? raw : (raw & NMASK);
endmodule

// File: rtl/bitstep_flags.sv
module bitstep_flags #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          wide_i,
  input  logic [DW-1:0] res_i,
  output logic          neg_o,
  output logic          zero_o
);
  assign neg_o  = wide_i ? res_i[DW-1] : res_i[NW-1];
  assign zero_o = wide_i ? (res_i == '0) : (res_i[NW-1:0] == '0);
endmodule

// File: rtl/bitstep_regs.sv
module bitstep_regs #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          to_mem_i,
  input  logic          wide_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] res_i,
  input  logic          neg_i,
  input  logic          zero_i,
  input  logic          carry_i,
  output logic          valid_o,
  output logic          acc_we_o,
  output logic [DW-1:0] acc_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          neg_o,
  output logic          zero_o,
  output logic          carry_o
);
  logic [DW-1:0] acc_nxt;
  assign acc_nxt = wide_i ? res_i : {acc_i[DW-1:NW], res_i[NW-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      acc_we_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      acc_o       <= '0;
      mem_wdata_o <= '0;
      neg_o       <= 1'b0;
      zero_o      <= 1'b0;
      carry_o     <= 1'b0;
    end else begin
      valid_o  <= fire_i;
      acc_we_o <= fire_i && !to_mem_i;
      mem_we_o <= fire_i && to_mem_i;
      if (fire_i) begin
        neg_o   <= neg_i;
        zero_o  <= zero_i;
        carry_o <= carry_i;
        if (to_mem_i) mem_wdata_o <= res_i;
        else          acc_o       <= acc_nxt;
      end
    end
  end
endmodule

// File: rtl/bitstep_unit.sv
module bitstep_unit
  import bitstep_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic          wide_i,
  input  logic          to_mem_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mem_i,
  input  logic          carry_i,
  output logic          valid_o,
  output logic          acc_we_o,
  output logic [DW-1:0] acc_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          neg_o,
  output logic          zero_o,
  output logic          carry_o
);
  logic [DW-1:0] opnd, res;
  logic          c_nxt, n_nxt, z_nxt, fire;

  assign opnd = to_mem_i ? mem_i : acc_i;
  assign fire = start_i && op_known(op_i);

  bitstep_alu #(.DW(DW), .NW(NW)) i_alu (
    .op_i(op_i), .wide_i(wide_i), .opnd_i(opnd), .carry_i(carry_i),
    .res_o(res), .carry_o(c_nxt)
  );

  bitstep_flags #(.DW(DW), .NW(NW)) i_flags (
    .wide_i(wide_i), .res_i(res), .neg_o(n_nxt), .zero_o(z_nxt)
  );

  bitstep_regs #(.DW(DW), .NW(NW)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .to_mem_i(to_mem_i),
    .wide_i(wide_i), .acc_i(acc_i), .res_i(res), .neg_i(n_nxt),
    .zero_i(z_nxt), .carry_i(c_nxt), .valid_o(valid_o), .acc_we_o(acc_we_o),
    .acc_o(acc_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .neg_o(neg_o), .zero_o(zero_o), .carry_o(carry_o)
  );

  p_valid_follows_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(start_i) && ($past(op_i) <= 3'd5));

  p_one_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_we_o, mem_we_o}));

  p_invalid_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i > 3'd5) |=> !valid_o && !acc_we_o && !mem_we_o &&
      $stable(carry_o) && $stable(neg_o) && $stable(zero_o) && $stable(acc_o));

  p_step_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (op_i == 3'd4 || op_i == 3'd5)) |=> carry_o == $past(carry_i));

  p_keep_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i <= 3'd5 && !wide_i && !to_mem_i) |=>
      acc_o[DW-1:NW] == $past(acc_i[DW-1:NW]));

  p_mem_narrow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i <= 3'd5 && !wide_i && to_mem_i) |=>
      mem_wdata_o[DW-1:NW] == '0 && $stable(acc_o));
endmodule

// File: tb/test_bitstep_unit.sv
module test_bitstep_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        wide_i = 1'b0, to_mem_i = 1'b0, carry_i = 1'b0;
  logic [15:0] acc_i = '0, mem_i = '0;
  logic        valid_o, acc_we_o, mem_we_o, neg_o, zero_o, carry_o;
  logic [15:0] acc_o, mem_wdata_o;

  always #4 clk_i = ~clk_i;

  bitstep_unit i_bitstep_unit (.*);

  int n_chk = 0, n_bad = 0;
  logic [15:0] e_acc = '0, e_mem = '0;
  logic        e_n = 1'b0, e_z = 1'b0, e_c = 1'b0;

  task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns {carry, result} with narrow results cleared above bit 7
  function automatic logic [16:0] model(logic [2:0] op, logic w, logic [15:0] v, logic c);
    logic [15:0] x, r;
    logic t, co;
    x = w ? v : {8'h00, v[7:0]};
    t = w ? x[15] : x[7];
    co = c;
    case (op)
      3'd0: begin r = x << 1; co = t; end
      3'd1: begin r = x >> 1; co = x[0]; end
      3'd2: begin r = {x[14:0], c}; co = t; end
      3'd3: begin r = x >> 1; if (w) r[15] = c; else r[7] = c; co = x[0]; end
      3'd4: r = x + 16'd1;
      3'd5: r = x - 16'd1;
      default: r = x;
    endcase
    if (!w) r[15:8] = 8'h00;
    return {co, r};
  endfunction

  task automatic run(logic [2:0] op, logic w, logic tm, logic [15:0] a,
                     logic [15:0] m, logic c, string tag);
    logic [16:0] mr;
    logic ok;
    @(negedge clk_i);
    op_i = op; wide_i = w; to_mem_i = tm; acc_i = a; mem_i = m; carry_i = c;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    ok = (op <= 3'd5);
    if (ok) begin
      mr  = model(op, w, tm ? m : a, c);
      e_c = mr[16];
      e_n = w ? mr[15] : mr[7];
      e_z = w ? (mr[15:0] == 0) : (mr[7:0] == 0);
      if (tm) e_mem = mr[15:0];
      else    e_acc = w ? mr[15:0] : {a[15:8], mr[7:0]};
    end
    chk({tag, " R11 valid"}, {16'h0, valid_o}, {16'h0, ok});
    chk({tag, " R9 acc_we"}, {16'h0, acc_we_o}, {16'h0, ok && !tm});
    chk({tag, " R9 mem_we"}, {16'h0, mem_we_o}, {16'h0, ok && tm});
    chk({tag, " R8 acc"}, {1'b0, acc_o}, {1'b0, e_acc});
    chk({tag, " R9 mem"}, {1'b0, mem_wdata_o}, {1'b0, e_mem});
    chk({tag, " carry"}, {16'h0, carry_o}, {16'h0, e_c});
    chk({tag, " R7 nz"}, {15'h0, neg_o, zero_o}, {15'h0, e_n, e_z});
    @(negedge clk_i);
    chk({tag, " R11 drop"}, {16'h0, valid_o}, 17'h0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    string tags [8];
    void'($urandom(32'h5eed_0042));
    tags = '{"R2", "R3", "R4", "R5", "R6", "R6", "R10", "R10"};
    repeat (3) @(negedge clk_i);
    chk("R1 reset strobes", {14'h0, valid_o, acc_we_o, mem_we_o}, 17'h0);
    chk("R1 reset data", {1'b0, acc_o | mem_wdata_o}, 17'h0);
    chk("R1 reset flags", {14'h0, neg_o, zero_o, carry_o}, 17'h0);
    rst_ni = 1'b1;

    run(3'd0, 1'b0, 1'b0, 16'hA580, 16'h0, 1'b0, "R2 shl narrow acc");
    run(3'd0, 1'b1, 1'b1, 16'h0, 16'h4001, 1'b1, "R2 shl wide mem");
    run(3'd1, 1'b0, 1'b1, 16'h0, 16'hFF01, 1'b0, "R3 shr narrow mem");
    run(3'd2, 1'b1, 1'b0, 16'h8000, 16'h0, 1'b1, "R4 rol wide acc");
    run(3'd3, 1'b1, 1'b0, 16'h0001, 16'h0, 1'b1, "R5 ror wide acc");
    run(3'd3, 1'b0, 1'b0, 16'h1201, 16'h0, 1'b1, "R5 ror narrow acc");
    run(3'd4, 1'b0, 1'b0, 16'h33FF, 16'h0, 1'b1, "R6 inc wrap narrow");
    run(3'd5, 1'b1, 1'b1, 16'h0, 16'h0000, 1'b0, "R6 dec wrap wide");
    run(3'd6, 1'b1, 1'b0, 16'h1234, 16'h5678, 1'b0, "R10 code6");
    run(3'd7, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b1, "R10 code7");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      run(op, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
          1'($urandom), {"rand ", tags[op]});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule